// File: doc/BRIEF.md
# Multiplier Final-Stage Merge Adder

This block is the last stage of a signed multiplier whose partial-product tree has been cut into two halves that are compressed side by side. The lower half delivers a result that covers product weights 0 up to OP_W+2. Its top three bits are carries that spill into the area of the upper half. The upper half delivers the bits of weight OP_W up to 2·OP_W−1. The lower OP_W product bits come straight from the lower half and do not pass through this block. This block produces the upper OP_W product bits.

A three-bit ripple-carry adder sums the region where the two halves overlap. No adder touches the bits above that region. Each group of those bits feeds a plus-one converter, and a two-way multiplexer passes either the raw bits or the incremented bits. The first group's select is the ripple carry-out. Every group except the topmost also produces an all-ones flag. That flag is carried through the multiplexer as an extra most significant bit, with a zero appended on the raw side, and it becomes the select of the group above.

Group widths grow toward the MSB:
- With OP_W = 8 there is a single 5-bit group.
- With OP_W = 16 there are four groups of 2, 3, 4 and 4 bits, starting from the LSB.

The block is purely combinational and has no clock and no reset.

Top module: `hxa_merge_adder`

## Requirements
- R1: prod_hi bits [2:0] equal the low three bits of lo_res[OP_W+2:OP_W] + hi_res[2:0].
- R2: When that three-bit overlap sum produces no carry, prod_hi[OP_W-1:3] equals hi_res[OP_W-1:3] unchanged.
- R3: When the overlap sum carries, prod_hi[OP_W-1:3] equals hi_res[OP_W-1:3] + 1, modulo 2^(OP_W-3).
- R4: For any inputs, prod_hi equals (hi_res + lo_res[OP_W+2:OP_W]) mod 2^OP_W. This is the upper half of lo_res + (hi_res << OP_W).
- R5: A group above the lowest one increments only when the overlap sum carries and every lower group is all ones. All bits above the first group that is not all ones are passed through unchanged.
- R6: An all-ones upper region wraps to all zeros when the overlap sum carries, and stays all ones when it does not.
- R7: lo_res bits [OP_W-1:0] have no effect on prod_hi.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lo_res | input | OP_W+3 | Lower-half result, weights 0 to OP_W+2 |
| hi_res | input | OP_W | Upper-half result, weights OP_W to 2·OP_W−1 |
| prod_hi | output | OP_W | Product bits of weight OP_W to 2·OP_W−1 |

## Verification
Every result of this block is combinational, so prod_hi is due in the same cycle in which lo_res and hi_res change. It has zero register delay. The bench applies each input pair just after a rising edge and samples prod_hi at the next falling edge, half a period later. This gives the ripple path and the group select chain time to settle before the value is compared. Both the 8-bit and the 16-bit configuration are instantiated and checked with the same timing.

// File: rtl/hxa_pkg.sv
package hxa_pkg;

    // Number of plus-one groups above the overlap region.
    function automatic int grp_count(input int op_w);
        return (op_w == 8) ? 1 : 4;
    endfunction

    // Width of group idx, counted from the LSB; widths grow upward.
    function automatic int grp_width(input int op_w, input int idx);
        if (op_w == 8) begin
            return 5;
        end
        case (idx)
            0:       return 2;
            1:       return 3;
            default: return 4;
        endcase
    endfunction

    // Offset of group idx relative to the first bit above the overlap.
    function automatic int grp_base(input int op_w, input int idx);
        int b;
        b = 0;
        for (int i = 0; i < idx; i++) begin
            b += grp_width(op_w, i);
        end
        return b;
    endfunction

endpackage

// File: rtl/hxa_ripple.sv
module hxa_ripple #(
    parameter int W = 3
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] cy;

    assign cy[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i]  = a[i] ^ b[i] ^ cy[i];
        assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
    end

    assign cout = cy[W];
endmodule

// File: rtl/hxa_sel_grp.sv
module hxa_sel_grp #(
    parameter int W         = 4,
    parameter bit CARRY_OUT = 1'b1
) (
    input  logic [W-1:0] raw,
    input  logic         sel,
    output logic [W-1:0] res,
    output logic         sel_up
);
    logic [W-1:0] inc;
    logic [W:0]   run;

    // Plus-one conversion: a bit flips when every bit below it is one.
    always_comb begin
        run[0] = 1'b1;
        for (int i = 0; i < W; i++) begin
            inc[i]   = raw[i] ^ run[i];
            run[i+1] = run[i] & raw[i];
        end
    end

    if (CARRY_OUT) begin : g_co
        logic [W:0] conv;
        logic [W:0] plain;
        logic [W:0] picked;
        assign conv   = {run[W], inc};
        assign plain  = {1'b0, raw};
        assign picked = sel ? conv : plain;
        assign res    = picked[W-1:0];
        assign sel_up = picked[W];
    end else begin : g_nco
        logic run_top_unused;
        assign run_top_unused = run[W];
        assign res    = sel ? inc : raw;
        assign sel_up = 1'b0;
    end
endmodule

// File: rtl/hxa_merge_adder.sv
module hxa_merge_adder
    import hxa_pkg::*;
#(
    parameter int OP_W  = 16,
    parameter int OVL_W = 3
) (
    input  logic [OP_W+OVL_W-1:0] lo_res,
    input  logic [OP_W-1:0]       hi_res,
    output logic [OP_W-1:0]       prod_hi
);
    localparam int LO_W = OP_W + OVL_W;
    localparam int NGRP = grp_count(OP_W);

    logic [OVL_W-1:0] ovl_sum;
    logic             rip_co;
    logic [NGRP:0]    sel_c;
    logic             top_carry_unused;
    logic             lo_pass_unused;

    hxa_ripple #(.W(OVL_W)) u_rip (
        .a    (lo_res[LO_W-1:OP_W]),
        .b    (hi_res[OVL_W-1:0]),
        .sum  (ovl_sum),
        .cout (rip_co)
    );

    assign prod_hi[OVL_W-1:0] = ovl_sum;
    assign sel_c[0]           = rip_co;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int GW = grp_width(OP_W, g);
        localparam int GB = OVL_W + grp_base(OP_W, g);
        localparam bit CO = (g < NGRP - 1);

        hxa_sel_grp #(.W(GW), .CARRY_OUT(CO)) u_grp (
            .raw    (hi_res[GB+GW-1:GB]),
            .sel    (sel_c[g]),
            .res    (prod_hi[GB+GW-1:GB]),
            .sel_up (sel_c[g+1])
        );
    end

    // The top carry is dropped: the product is truncated to 2*OP_W bits.
    assign top_carry_unused = sel_c[NGRP];
    // The low OP_W bits of the lower half are final product bits elsewhere.
    assign lo_pass_unused   = ^lo_res[OP_W-1:0];
endmodule

// File: rtl/hxa_merge_adder_chk.sv
module hxa_merge_adder_chk #(
    parameter int OP_W  = 16,
    parameter int OVL_W = 3
) (
    input logic [OP_W+OVL_W-1:0] lo_res,
    input logic [OP_W-1:0]       hi_res,
    input logic [OP_W-1:0]       prod_hi,
    input logic                  rip_co
);
    localparam int LO_W = OP_W + OVL_W;
    localparam int UP_W = OP_W - OVL_W;

    logic [OVL_W:0]  ovl_ref;
    logic [UP_W-1:0] up_inc;
    logic [OP_W-1:0] tot_ref;

    always_comb begin
        ovl_ref = {1'b0, lo_res[LO_W-1:OP_W]} + {1'b0, hi_res[OVL_W-1:0]};
        up_inc  = hi_res[OP_W-1:OVL_W] + UP_W'(1);
        tot_ref = hi_res + OP_W'(lo_res[LO_W-1:OP_W]);
    end

    always_comb begin
        if (!$isunknown({lo_res, hi_res, prod_hi, rip_co})) begin
            // R1
            p_ovl_sum_r1: assert (prod_hi[OVL_W-1:0] == ovl_ref[OVL_W-1:0]);
            // R2
            p_pass_r2: assert (ovl_ref[OVL_W] || prod_hi[OP_W-1:OVL_W] == hi_res[OP_W-1:OVL_W]);
            // R3
            p_inc_r3: assert (!ovl_ref[OVL_W] || prod_hi[OP_W-1:OVL_W] == up_inc);
            // R3: the ripple carry that drives the first select matches the overlap sum
            p_sel_src_r3: assert (rip_co == ovl_ref[OVL_W]);
            // R4
            p_total_r4: assert (prod_hi == tot_ref);
        end
    end
endmodule

bind hxa_merge_adder hxa_merge_adder_chk #(.OP_W(OP_W), .OVL_W(OVL_W)) u_chk (
    .lo_res  (lo_res),
    .hi_res  (hi_res),
    .prod_hi (prod_hi),
    .rip_co  (rip_co)
);

// File: tb/hxa_merge_adder_bench.sv
module hxa_merge_adder_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    logic [18:0] lo16 = '0;
    logic [15:0] hi16 = '0;
    logic [15:0] p16;
    logic [10:0] lo8 = '0;
    logic [7:0]  hi8 = '0;
    logic [7:0]  p8;

    always #2.5 clk = ~clk;

    hxa_merge_adder #(.OP_W(16), .OVL_W(3)) u_hxa_merge_adder (
        .lo_res (lo16), .hi_res (hi16), .prod_hi (p16)
    );

    hxa_merge_adder #(.OP_W(8), .OVL_W(3)) u_hxa_merge_adder_w8 (
        .lo_res (lo8), .hi_res (hi8), .prod_hi (p8)
    );

    function automatic logic [15:0] ref16(input logic [18:0] lo, input logic [15:0] hi);
        return hi + {13'd0, lo[18:16]};
    endfunction

    function automatic logic [7:0] ref8(input logic [10:0] lo, input logic [7:0] hi);
        return hi + {5'd0, lo[10:8]};
    endfunction

    task automatic chk16(input logic [18:0] lo, input logic [15:0] hi,
                         input logic [15:0] exp, input string req);
        @(posedge clk);
        lo16 = lo;
        hi16 = hi;
        @(negedge clk);
        n_chk++;
        if (p16 !== exp) begin
            n_fail++;
            $display("FAIL %s w16 lo=%h hi=%h actual %h expected %h", req, lo, hi, p16, exp);
        end
    endtask

    task automatic chk8(input logic [10:0] lo, input logic [7:0] hi,
                        input logic [7:0] exp, input string req);
        @(posedge clk);
        lo8 = lo;
        hi8 = hi;
        @(negedge clk);
        n_chk++;
        if (p8 !== exp) begin
            n_fail++;
            $display("FAIL %s w8 lo=%h hi=%h actual %h expected %h", req, lo, hi, p8, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        n_chk++;
        if (p16 !== 16'h0 || p8 !== 8'h0) begin
            n_fail++;
            $display("FAIL R4 zero inputs actual %h/%h expected 0000/00", p16, p8);
        end
    endtask

    // R1: overlap bits 5 + 6 = 11, low three bits 3, carry into the upper region
    task automatic t_overlap();
        chk16({3'b101, 16'h0}, 16'h0006, 16'h000B, "R1");
        chk8({3'b011, 8'h0}, 8'h02, 8'h05, "R1");
    endtask

    // R2: no overlap carry, the upper bits are passed through
    task automatic t_passthrough();
        chk16({3'd2, 16'h1234}, 16'hA5A1, 16'hA5A3, "R2");
        chk8({3'd3, 8'h77}, 8'hB4, 8'hB7, "R2");
    endtask

    // R3: overlap carry, the upper region is incremented
    task automatic t_increment();
        chk16({3'd7, 16'h0}, 16'h1239, 16'h1240, "R3");
        chk8({3'd4, 8'h0}, 8'h4C, 8'h50, "R3");
    endtask

    // R5: the select chain stops at the first group that is not all ones
    task automatic t_chain();
        chk16({3'd1, 16'h0}, 16'h005F, 16'h0060, "R5");
        chk16({3'd1, 16'h0}, 16'h5FFF, 16'h6000, "R5");
        chk16({3'd1, 16'h0}, 16'hF0FF, 16'hF100, "R5");
        chk16({3'd0, 16'h0}, 16'h0FF8, 16'h0FF8, "R5");
    endtask

    // R6: an all-ones upper region wraps on carry and holds without it
    task automatic t_allones();
        chk16({3'd1, 16'h0}, 16'hFFFF, 16'h0000, "R6");
        chk16({3'd7, 16'h0}, 16'hFFF8, 16'hFFFF, "R6");
        chk8({3'd1, 8'h0}, 8'hFF, 8'h00, "R6");
        chk8({3'd7, 8'h0}, 8'hF8, 8'hFF, "R6");
    endtask

    // R7: the low lower-half bits do not reach the output
    task automatic t_low_ignored();
        chk16({3'd6, 16'h0000}, 16'h3C3E, 16'h3C44, "R7");
        chk16({3'd6, 16'hFFFF}, 16'h3C3E, 16'h3C44, "R7");
        chk8({3'd5, 8'hFF}, 8'h9B, 8'hA0, "R7");
        chk8({3'd5, 8'h00}, 8'h9B, 8'hA0, "R7");
    endtask

    // R4: random operand pairs against a plain addition
    task automatic t_random();
        for (int k = 0; k < 150; k++) begin
            logic [18:0] l16;
            logic [15:0] h16;
            logic [10:0] l8;
            logic [7:0]  h8;
            l16 = 19'($urandom);
            h16 = 16'($urandom);
            l8  = 11'($urandom);
            h8  = 8'($urandom);
            chk16(l16, h16, ref16(l16, h16), "R4");
            chk8(l8, h8, ref8(l8, h8), "R4");
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_overlap();
        t_passthrough();
        t_increment();
        t_chain();
        t_allones();
        t_low_ignored();
        t_random();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule